// File: doc/BRIEF.md
# Multi-Standard Audio Serial Transmitter

This block is a bus-master audio serializer. It generates its own bit clock (`bck`) and word select (`ws`) from the system clock and shifts audio samples out on `sd`, one bit per bit-clock period. A single datapath serves four framing styles: the classic two-channel format in which word select leads the data by one bit, left-justified, right-justified, and a single-slot PCM format with a short or long frame sync. Samples of 16, 24 or 32 bits travel in 16- or 32-bit slots.

Configuration arrives on plain pins. It is captured only while `enable` is low and is frozen for as long as `enable` stays high. Samples enter through a valid/ready stream with a one-word holding register. The sender may hold `s_valid` high for as long as it likes. `s_ready` is high only while the holding register is empty. A word is accepted on the clock edge where `s_valid` and `s_ready` are both high, and `s_data` must stay stable until that edge. The transmitter drains the holding register at the start of every slot. If the register is empty at that moment, the previous word is sent again and `underrun` is raised.

Top module: `audio_serial_tx`

## Requirements
- R1: A bit period lasts 2*(`bck_div`+1) clock cycles. `bck` is low for the first half of each period and high for the second half. `sd` and `ws` change only as `bck` falls, and the first bit starts in the cycle after `enable` is seen high. While idle, `bck` rests at `cfg_idle_hi`. The idle level never changes which edge launches data.
- R2: `cfg_len` selects the sample width: 0 for 16 bits, 1 for 24 bits, 2 for 32 bits. The slot is 16 bits only when `cfg_len`=0 and `cfg_wide_slot`=0, and 32 bits otherwise. A stereo frame holds two slots, left then right. A PCM frame holds one slot.
- R3: With `cfg_std`=0, `ws` is low for the left slot and high for the right slot. It changes on the last bit of the preceding slot, one bit period before the MSB.
- R4: With `cfg_std`=1, `ws` changes together with the MSB, which is the first bit of the slot. Bits after the LSB are driven low.
- R5: With `cfg_std`=2, the sample ends on the last bit of its slot. The leading pad bits are driven low, and `ws` changes on the first bit of the slot, as in R4.
- R6: With `cfg_std`=3 and `cfg_long_sync`=0, `ws` is high for exactly one bit period, the last bit of every frame, which is immediately before the MSB.
- R7: With `cfg_std`=3 and `cfg_long_sync`=1, `ws` is high for the first 13 bits of every frame, starting with the MSB.
- R8: `s_data` bit (width-1) is the MSB of the sample, and bits above the width are ignored. Successive accepted words fill successive slots. `s_ready` is low in the cycle after an acceptance and stays low until the slot start that drains the holding register.
- R9: If the holding register is empty when a slot starts, that slot repeats the previous word, and `underrun` is high for exactly the one cycle in which the slot's first bit appears.
- R10: All configuration pins, including `bck_div`, are captured only while `enable` is low. Changes made while `enable` is high do not affect the output.
- R11: With `cfg_len`=3, raising `enable` starts nothing. `bck` stays at its idle level, `ws` and `sd` stay low, and no sample is consumed.
- R12: In the cycle after `enable` is seen low, `ws`, `sd` and `underrun` are low and `bck` is at the captured idle level.
- R13: During reset `ws`, `sd`, `underrun` and `bck` are low and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Starts framing when high, stops it when low |
| cfg_std | input | 2 | Framing style |
| cfg_len | input | 2 | Sample width code |
| cfg_wide_slot | input | 1 | Selects a 32-bit slot for 16-bit samples |
| cfg_idle_hi | input | 1 | Idle level of `bck` |
| cfg_long_sync | input | 1 | PCM long frame sync |
| bck_div | input | DIV_W | Half-period of the bit clock, minus one |
| s_valid | input | 1 | Sample offered |
| s_data | input | SAMPLE_W | Sample word, right-aligned |
| s_ready | output | 1 | Holding register empty |
| bck | output | 1 | Bit clock |
| ws | output | 1 | Word select / frame sync |
| sd | output | 1 | Serial data |
| underrun | output | 1 | One-cycle pulse when a slot repeats its previous word |

## Verification
Every output is registered at the launch edge. The bit for index k is therefore visible in the cycle after edge P0+k*2*(div+1), where P0 is the edge that sees `enable` high. The bench samples on the falling system clock half a cycle after that edge. It samples again div+1 cycles later to see `bck` high. `underrun` is due in the same cycle as the first bit of the failing slot, and it is checked there and one cycle later. The checks of `s_ready` fall in the cycle after an acceptance, and the idle checks in the cycle after `enable` drops.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  typedef enum logic [1:0] {
    STD_LEAD   = 2'd0,
    STD_LEFT   = 2'd1,
    STD_RIGHT  = 2'd2,
    STD_PCM    = 2'd3
  } tx_std_e;

  typedef enum logic [1:0] {
    LEN_16  = 2'd0,
    LEN_24  = 2'd1,
    LEN_32  = 2'd2,
    LEN_BAD = 2'd3
  } tx_len_e;

  typedef struct packed {
    tx_std_e std;
    tx_len_e dlen;
    logic    wide_slot;
    logic    idle_hi;
    logic    long_sync;
  } tx_cfg_t;

  function automatic int data_bits(tx_len_e l);
    case (l)
      LEN_16:  return 16;
      LEN_24:  return 24;
      default: return 32;
    endcase
  endfunction

  function automatic int slot_bits(tx_len_e l, logic wide);
    return (l == LEN_16 && !wide) ? 16 : 32;
  endfunction

endpackage

// File: rtl/audio_tx_cfg_latch.sv
module audio_tx_cfg_latch
  import audio_tx_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  tx_cfg_t          cfg_in,
  input  logic [DIV_W-1:0] div_in,
  output tx_cfg_t          cfg_q,
  output logic [DIV_W-1:0] div_q,
  output logic             legal
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      div_q <= '0;
    end else if (!enable) begin
      cfg_q <= cfg_in;
      div_q <= div_in;
    end
  end

  assign legal = (cfg_q.dlen != LEN_BAD);

endmodule

// File: rtl/audio_tx_bitclk.sv
module audio_tx_bitclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             start,
  input  logic             idle_hi,
  input  logic [DIV_W-1:0] div,
  output logic             bck,
  output logic             launch
);

  logic [DIV_W-1:0] cnt;
  logic             wrap;

  assign wrap   = (cnt == div);
  assign launch = start || (go && wrap && bck);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck <= 1'b0;
      cnt <= '0;
    end else if (!go) begin
      bck <= idle_hi;
      cnt <= '0;
    end else if (start) begin
      bck <= 1'b0;
      cnt <= '0;
    end else if (wrap) begin
      bck <= ~bck;
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end

endmodule

// File: rtl/audio_tx_hold_buf.sv
module audio_tx_hold_buf #(
  parameter int SAMPLE_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  input  logic                take,
  output logic                full,
  output logic [SAMPLE_W-1:0] word
);

  assign s_ready = !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else if (s_valid && s_ready) begin
      full <= 1'b1;
      word <= s_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

endmodule

// File: rtl/audio_tx_framer.sv
module audio_tx_framer
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W  = 32,
  parameter int POS_W     = 6,
  parameter int LONG_SYNC = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic                start,
  input  logic                launch,
  input  tx_cfg_t             cfg,
  input  logic                buf_full,
  input  logic [SAMPLE_W-1:0] buf_word,
  output logic                take,
  output logic                ws,
  output logic                sd,
  output logic                underrun
);

  localparam int IDX_W = $clog2(SAMPLE_W);

  logic [POS_W-1:0]    bit_k, k_next, k_after, pos_next;
  logic [POS_W-1:0]    slot_len, data_len, pad_len, bit_idx;
  logic [POS_W:0]      frame_len, last_k;
  logic [SAMPLE_W-1:0] word_q, word_next;
  logic                slot_edge, ws_next, sd_next, has_bit, in_right;

  always_comb begin
    slot_len  = POS_W'(slot_bits(cfg.dlen, cfg.wide_slot));
    data_len  = POS_W'(data_bits(cfg.dlen));
    pad_len   = slot_len - data_len;
    frame_len = (cfg.std == STD_PCM) ? {1'b0, slot_len} : {slot_len, 1'b0};
    last_k    = frame_len - (POS_W+1)'(1);

    if (start || ({1'b0, bit_k} == last_k)) k_next = '0;
    else                                    k_next = bit_k + POS_W'(1);

    if ({1'b0, k_next} == last_k) k_after = '0;
    else                          k_after = k_next + POS_W'(1);

    pos_next  = k_next & (slot_len - POS_W'(1));
    in_right  = (k_next >= slot_len);
    slot_edge = launch && (pos_next == '0);
    take      = slot_edge && buf_full;
    word_next = take ? buf_word : word_q;

    case (cfg.std)
      STD_LEAD:  ws_next = (k_after >= slot_len);
      STD_PCM:   ws_next = cfg.long_sync ? (k_next < POS_W'(LONG_SYNC))
                                         : ({1'b0, k_next} == last_k);
      default:   ws_next = in_right;
    endcase

    if (cfg.std == STD_RIGHT) begin
      has_bit = (pos_next >= pad_len);
      bit_idx = slot_len - POS_W'(1) - pos_next;
    end else begin
      has_bit = (pos_next < data_len);
      bit_idx = data_len - POS_W'(1) - pos_next;
    end
    sd_next = has_bit && word_next[bit_idx[IDX_W-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_k    <= '0;
      word_q   <= '0;
      ws       <= 1'b0;
      sd       <= 1'b0;
      underrun <= 1'b0;
    end else if (!go) begin
      bit_k    <= '0;
      ws       <= 1'b0;
      sd       <= 1'b0;
      underrun <= 1'b0;
    end else if (launch) begin
      bit_k    <= k_next;
      word_q   <= word_next;
      ws       <= ws_next;
      sd       <= sd_next;
      underrun <= slot_edge && !buf_full;
    end else begin
      underrun <= 1'b0;
    end
  end

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import audio_tx_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int SAMPLE_W  = 32,
  parameter int LONG_SYNC = 13
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [1:0]          cfg_std,
  input  logic [1:0]          cfg_len,
  input  logic                cfg_wide_slot,
  input  logic                cfg_idle_hi,
  input  logic                cfg_long_sync,
  input  logic [DIV_W-1:0]    bck_div,
  input  logic                s_valid,
  input  logic [SAMPLE_W-1:0] s_data,
  output logic                s_ready,
  output logic                bck,
  output logic                ws,
  output logic                sd,
  output logic                underrun
);

  localparam int POS_W = $clog2(2 * SAMPLE_W);

  tx_cfg_t             cfg_in, cfg_q;
  logic [DIV_W-1:0]    div_q;
  logic                legal, active, start, go, launch, take, buf_full;
  logic [SAMPLE_W-1:0] buf_word;
  logic                len_bad, idle_hi_q;

  always_comb begin
    cfg_in.std       = tx_std_e'(cfg_std);
    cfg_in.dlen      = tx_len_e'(cfg_len);
    cfg_in.wide_slot = cfg_wide_slot;
    cfg_in.idle_hi   = cfg_idle_hi;
    cfg_in.long_sync = cfg_long_sync;
  end

  audio_tx_cfg_latch #(.DIV_W(DIV_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_in(cfg_in), .div_in(bck_div),
    .cfg_q(cfg_q), .div_q(div_q), .legal(legal)
  );

  assign start     = enable && !active && legal;
  assign go        = start || (enable && active);
  assign len_bad   = !legal;
  assign idle_hi_q = cfg_q.idle_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active <= 1'b0;
    else        active <= go;
  end

  audio_tx_bitclk #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .go(go), .start(start),
    .idle_hi(cfg_q.idle_hi), .div(div_q),
    .bck(bck), .launch(launch)
  );

  audio_tx_hold_buf #(.SAMPLE_W(SAMPLE_W)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .take(take), .full(buf_full), .word(buf_word)
  );

  audio_tx_framer #(
    .SAMPLE_W(SAMPLE_W), .POS_W(POS_W), .LONG_SYNC(LONG_SYNC)
  ) u_frm (
    .clk(clk), .rst_n(rst_n), .go(go), .start(start), .launch(launch),
    .cfg(cfg_q), .buf_full(buf_full), .buf_word(buf_word),
    .take(take), .ws(ws), .sd(sd), .underrun(underrun)
  );

endmodule

// File: rtl/audio_tx_checker.sv
module audio_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic s_valid,
  input logic s_ready,
  input logic bck,
  input logic ws,
  input logic sd,
  input logic underrun,
  input logic len_bad,
  input logic idle_hi_q
);

  // R12: dropping enable silences the serial outputs on the next cycle
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!ws && !sd && !underrun));

  // R9: underrun never lasts longer than one cycle
  assert_underrun_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  // R8: an accepted word fills the holding register, so ready drops
  assert_ready_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R1: while running, ws and sd move only together with a falling bck
  assert_launch_on_fall_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(enable) && (ws != $past(ws) || sd != $past(sd))) |-> !bck);

  // R11: an illegal width code keeps the block idle
  assert_bad_len_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && len_bad) |=> (!ws && !sd && bck == idle_hi_q));

endmodule

bind audio_serial_tx audio_tx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable),
  .s_valid(s_valid), .s_ready(s_ready),
  .bck(bck), .ws(ws), .sd(sd), .underrun(underrun),
  .len_bad(len_bad), .idle_hi_q(idle_hi_q)
);

// File: tb/test_audio_serial_tx.sv
`timescale 1ns/1ps
module test_audio_serial_tx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  cfg_std = '0, cfg_len = '0;
  logic        cfg_wide_slot = 1'b0, cfg_idle_hi = 1'b0, cfg_long_sync = 1'b0;
  logic [7:0]  bck_div = '0;
  logic        s_valid, s_ready, bck, ws, sd, underrun;
  logic [31:0] s_data;

  logic        feed_on = 1'b0, man_mode = 1'b0, man_valid = 1'b0;
  logic [31:0] man_data = '0;
  int unsigned idx;
  int          n_checks = 0, n_errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] pattern(int n);
    logic [31:0] t = 32'(n + 1);
    return (t * 32'h9E3779B9) ^ 32'h5A5A0F0F;
  endfunction

  assign s_valid = man_mode ? man_valid : feed_on;
  assign s_data  = man_mode ? man_data  : pattern(int'(idx));

  always @(posedge clk or negedge rst_n)
    if (!rst_n) idx <= 0;
    else if (!man_mode && s_valid && s_ready) idx <= idx + 1;

  audio_serial_tx i_audio_serial_tx (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_std(cfg_std), .cfg_len(cfg_len), .cfg_wide_slot(cfg_wide_slot),
    .cfg_idle_hi(cfg_idle_hi), .cfg_long_sync(cfg_long_sync),
    .bck_div(bck_div), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .bck(bck), .ws(ws), .sd(sd), .underrun(underrun)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int dbits(int len);
    return len == 0 ? 16 : (len == 1 ? 24 : 32);
  endfunction
  function automatic int sbits(int len, int wide);
    return (len == 0 && wide == 0) ? 16 : 32;
  endfunction

  function automatic logic exp_ws(int std, int sl, int lsync, int k);
    int fl = (std == 3) ? sl : 2 * sl;
    int kk = k % fl;
    case (std)
      0: return ((kk + 1) % fl) >= sl;
      3: return lsync ? (kk < 13) : (kk == fl - 1);
      default: return kk >= sl;
    endcase
  endfunction

  function automatic logic exp_sd(int std, int db, int sl, logic [31:0] w, int pos);
    if (std == 2) return (pos >= sl - db) ? w[sl - 1 - pos] : 1'b0;
    return (pos < db) ? w[db - 1 - pos] : 1'b0;
  endfunction

  function automatic string std_tag(int std, int lsync);
    case (std)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return lsync ? "R7" : "R6";
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; enable = 1'b0; feed_on = 1'b0; man_mode = 1'b0; man_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_cfg(int std, int len, int wide, int idle, int lsync, int div, int frames);
    int sl = sbits(len, wide);
    int db = dbits(len);
    int fl = (std == 3) ? sl : 2 * sl;
    string t = std_tag(std, lsync);
    do_reset();
    cfg_std = 2'(std); cfg_len = 2'(len); cfg_wide_slot = 1'(wide);
    cfg_idle_hi = 1'(idle); cfg_long_sync = 1'(lsync); bck_div = 8'(div);
    feed_on = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "idle bck", 32'(bck), 32'(idle));
    enable = 1'b1;
    @(negedge clk);
    // R10: scramble every configuration pin while running
    cfg_std = ~cfg_std; cfg_len = ~cfg_len; cfg_wide_slot = ~cfg_wide_slot;
    cfg_idle_hi = ~cfg_idle_hi; cfg_long_sync = ~cfg_long_sync; bck_div = bck_div ^ 8'd1;
    for (int k = 0; k < frames * fl; k++) begin
      int pos = k % sl;
      chk({t, " R10"}, "ws", 32'(ws), 32'(exp_ws(std, sl, lsync, k)));
      chk({"R2 R8 ", t}, "sd", 32'(sd), 32'(exp_sd(std, db, sl, pattern(k / sl), pos)));
      chk("R1", "bck low half", 32'(bck), 32'd0);
      if (pos == 0) chk("R9", "no underrun when fed", 32'(underrun), 32'd0);
      repeat (div + 1) @(negedge clk);
      chk("R1", "bck high half", 32'(bck), 32'd1);
      repeat (div + 1) @(negedge clk);
    end
    enable = 1'b0;
    @(negedge clk);
    chk("R12", "idle ws", 32'(ws), 32'd0);
    chk("R12", "idle sd", 32'(sd), 32'd0);
    chk("R12", "idle bck", 32'(bck), 32'(idle));
  endtask

  task automatic underrun_test();
    logic [31:0] d0 = 32'h1234_ABCD, d1 = 32'h0000_C35A;
    logic [31:0] w;
    do_reset();
    cfg_std = 2'd1; cfg_len = 2'd0; cfg_wide_slot = 1'b0; cfg_idle_hi = 1'b0;
    cfg_long_sync = 1'b0; bck_div = 8'd0;
    man_mode = 1'b1; man_valid = 1'b1; man_data = d0;
    @(negedge clk);
    chk("R8", "ready after accept", 32'(s_ready), 32'd0);
    man_data = d1;
    @(negedge clk);
    chk("R8", "ready held low while full", 32'(s_ready), 32'd0);
    enable = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 48; k++) begin
      int pos = k % 16;
      w = (k < 16) ? d0 : d1;
      chk("R9", "sd", 32'(sd), 32'(exp_sd(1, 16, 16, w, pos)));
      chk("R9", "ws", 32'(ws), 32'(exp_ws(1, 16, 0, k)));
      if (pos == 0) chk("R9", "underrun at slot start", 32'(underrun), 32'(k == 32));
      @(negedge clk);
      if (pos == 0) chk("R9", "underrun one cycle", 32'(underrun), 32'd0);
      if (k == 0) begin
        chk("R8", "second word accepted", 32'(s_ready), 32'd0);
        man_valid = 1'b0;
      end
      @(negedge clk);
    end
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic bad_len_test();
    do_reset();
    cfg_std = 2'd0; cfg_len = 2'd3; cfg_idle_hi = 1'b1; bck_div = 8'd0;
    feed_on = 1'b1;
    repeat (3) @(negedge clk);
    enable = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk("R11", "bck idle", 32'(bck), 32'd1);
      chk("R11", "ws", 32'(ws), 32'd0);
      chk("R11", "sd", 32'(sd), 32'd0);
      chk("R11", "sample kept", 32'(s_ready), 32'd0);
    end
    enable = 1'b0;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R13", "reset ws", 32'(ws), 32'd0);
    chk("R13", "reset sd", 32'(sd), 32'd0);
    chk("R13", "reset bck", 32'(bck), 32'd0);
    chk("R13", "reset underrun", 32'(underrun), 32'd0);
    chk("R13", "reset ready", 32'(s_ready), 32'd1);
    for (int std = 0; std < 4; std++)
      for (int len = 0; len < 3; len++)
        for (int wide = 0; wide < 2; wide++)
          for (int idle = 0; idle < 2; idle++)
            for (int ls = 0; ls < ((std == 3) ? 2 : 1); ls++)
              run_cfg(std, len, wide, idle, ls, 0, 3);
    run_cfg(0, 1, 0, 1, 0, 2, 2);
    run_cfg(3, 0, 0, 0, 1, 3, 2);
    run_cfg(2, 0, 1, 0, 0, 1, 2);
    underrun_test();
    bad_len_test();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

endmodule